// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Controller

This block sits on the CPU write bus of a cartridge and turns a one-bit serial programming protocol into memory bank numbers. The block only acts on writes in the upper 32K of the CPU address space. Each such write carries a single payload bit. After five of these writes, the assembled 5-bit value is committed to one of four internal registers. The register is chosen by two address bits.

The block drives three kinds of output. The first is four 8K program-slot bank indices. The second is eight 1K character-page bank indices. The third is a two-bit nametable mirroring mode. The surrounding memories use these numbers to select ROM and RAM windows. Any write whose top data bit is set aborts a partial load and forces a known banking mode.

Top module: `serial_bank_mapper`

## Requirements
- R1: A write in the window with data bit 7 set clears the partial value and the bit count. It also sets 16K program mode, makes the lower 16K half the switchable one, and sets 8K character mode. No output changes because of that write.
- R2: Only writes with `wr_en` high and `wr_addr[15]` high are seen by the block. All other bus activity leaves every output and the internal load state unchanged.
- R3: Each other write in the window shifts the 5-bit value right and places `wr_data[0]` at bit 4. The first four such writes change no output. The fifth write commits the value to the register selected by `wr_addr[14:13]` and returns the count to zero. The selector values are: 0 control, 1 lower character, 2 upper character, 3 program.
- R4: Control bits [1:0] drive `mirror_mode` as follows: 0 single-screen low, 1 single-screen high, 2 vertical, 3 horizontal. Bit 4 set selects 4K character mode. Bit 3 set selects 16K program mode. Bit 2 set makes slots 0–1 switchable, and bit 2 clear makes slots 2–3 switchable. The mode bits affect only later bank writes.
- R5: A lower-character commit of value v behaves according to the character mode. In 4K mode it sets pages 0–3 to 4v+j for j = 0..3. In 8K mode it sets pages 0–7 to 4v+j for j = 0..7.
- R6: An upper-character commit of value v sets pages 4–7 to 4v+j, but only in 4K mode. In 8K mode it changes nothing.
- R7: A program commit of value v behaves according to the program mode. In 16K mode it sets the switchable slot pair to 2v and 2v+1. In 32K mode it sets slot i to 4·(v>>1)+i for i = 0..3.
- R8: Every program index is reduced modulo `PRG_BANKS`. Every character index is reduced modulo `CHR_PAGES`. Both counts are powers of two.
- R9: After reset, the signals take these values. Slot i holds `PRG_BANKS`-4+i, which is the last 32K. Page i holds i. `mirror_mode` is 2 (vertical). The modes are those of R1.
- R10: Outputs change on the clock edge that captures a committing write. They hold their value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_banks | output | 4*PW | 8K bank index per program slot, slot i at bits [i*PW +: PW] |
| chr_banks | output | 8*CW | 1K bank index per character page, page i at bits [i*CW +: CW] |
| mirror_mode | output | 2 | Nametable arrangement, encoded as in R4 |

## Verification
The bench builds the block with `PRG_BANKS`=8 and `CHR_PAGES`=32. With these sizes, most 5-bit values wrap past the end of both ROMs, so the modulo reduction of R8 is exercised by ordinary traffic as well as by the directed all-ones loads. The same sizes give three-bit program indices, so the reset placement in the last 32K of ROM and the 32K-mode alignment fall on small, easily read values. Random writes also reach the low address window and fire reset bits in the middle of loads, which exercises the abort and ignore paths alongside the commits.

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper #(
  parameter int PRG_BANKS = 32,
  parameter int CHR_PAGES = 128,
  localparam int PW = $clog2(PRG_BANKS),
  localparam int CW = $clog2(CHR_PAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [15:0]     wr_addr,
  input  logic [7:0]      wr_data,
  output logic [4*PW-1:0] prg_banks,
  output logic [8*CW-1:0] chr_banks,
  output logic [1:0]      mirror_mode
);

  logic [4:0] shreg;
  logic [2:0] cnt;
  logic       chr4k, prg16k, low_sw;
  logic [1:0] mirror_q;

  wire        hit    = wr_en & wr_addr[15];
  wire        clr    = wr_data[7];
  wire [4:0]  sh_nx  = {wr_data[0], shreg[4:1]};
  wire        commit = hit & ~clr & (cnt == 3'd4);
  wire [1:0]  sel    = wr_addr[14:13];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      chr4k    <= 1'b0;
      prg16k   <= 1'b1;
      low_sw   <= 1'b1;
      mirror_q <= 2'd2;
    end else if (hit) begin
      if (clr) begin
        shreg  <= '0;
        cnt    <= '0;
        chr4k  <= 1'b0;
        prg16k <= 1'b1;
        low_sw <= 1'b1;
      end else if (cnt == 3'd4) begin
        shreg <= sh_nx;
        cnt   <= '0;
        if (sel == 2'd0) begin
          mirror_q <= sh_nx[1:0];
          low_sw   <= sh_nx[2];
          prg16k   <= sh_nx[3];
          chr4k    <= sh_nx[4];
        end
      end else begin
        shreg <= sh_nx;
        cnt   <= cnt + 3'd1;
      end
    end
  end

  assign mirror_mode = mirror_q;

  wire [31:0] base16 = {26'd0, sh_nx, 1'b0};
  wire [31:0] base32 = {25'd0, sh_nx[4:1], 2'b00};
  wire [31:0] base4k = {25'd0, sh_nx, 2'b00};

  for (genvar i = 0; i < 4; i++) begin : g_prg
    localparam int HALF = i / 2;
    localparam logic [31:0] RST_IDX = 32'(PRG_BANKS - 4 + i);
    logic [PW-1:0] bank_q;
    wire [31:0] v16 = base16 + 32'(i % 2);
    wire [31:0] v32 = base32 + 32'(i);
    wire        mine16 = (HALF == 0) ? low_sw : ~low_sw;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q <= RST_IDX[PW-1:0];
      else if (commit && sel == 2'd3) begin
        if (!prg16k)
          bank_q <= v32[PW-1:0];
        else if (mine16)
          bank_q <= v16[PW-1:0];
      end
    end
    assign prg_banks[i*PW +: PW] = bank_q;
  end

  for (genvar p = 0; p < 8; p++) begin : g_chr
    localparam logic [31:0] RST_IDX = 32'(p);
    logic [CW-1:0] page_q;
    wire [31:0] lo_val = base4k + 32'(p);
    wire [31:0] hi_val = base4k + 32'(p % 4);
    wire        lo_hit = (sel == 2'd1) && ((p < 4) || !chr4k);
    wire        hi_hit = (sel == 2'd2) && (p >= 4) && chr4k;
    always_ff @(posedge clk) begin
      if (!rst_n)
        page_q <= RST_IDX[CW-1:0];
      else if (commit && lo_hit)
        page_q <= lo_val[CW-1:0];
      else if (commit && hi_hit)
        page_q <= hi_val[CW-1:0];
    end
    assign chr_banks[p*CW +: CW] = page_q;
  end

endmodule

// File: rtl/serial_bank_mapper_chk.sv
module serial_bank_mapper_chk #(
  parameter int PRG_BANKS = 32,
  parameter int CHR_PAGES = 128,
  localparam int PW = $clog2(PRG_BANKS),
  localparam int CW = $clog2(CHR_PAGES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [15:0]     wr_addr,
  input logic [7:0]      wr_data,
  input logic [4*PW-1:0] prg_banks,
  input logic [8*CW-1:0] chr_banks,
  input logic [1:0]      mirror_mode
);

  wire idle_bus = !wr_en || !wr_addr[15];

  assert_ignore_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_bus |=> ($stable(prg_banks) && $stable(chr_banks) && $stable(mirror_mode)));

  assert_clear_write_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15] && wr_data[7]) |=>
      ($stable(prg_banks) && $stable(chr_banks) && $stable(mirror_mode)));

  wire [PW-1:0] s0 = prg_banks[0*PW +: PW];
  wire [PW-1:0] s1 = prg_banks[1*PW +: PW];
  wire [PW-1:0] s2 = prg_banks[2*PW +: PW];
  wire [PW-1:0] s3 = prg_banks[3*PW +: PW];

  assert_prg_pairs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s0[0] == 1'b0) && (s1 == s0 + PW'(1)) && (s2[0] == 1'b0) && (s3 == s2 + PW'(1)));

  logic chr_groups_ok;
  always_comb begin
    chr_groups_ok = 1'b1;
    for (int h = 0; h < 2; h++) begin
      if (chr_banks[(4*h)*CW +: 2] != 2'b00) chr_groups_ok = 1'b0;
      for (int j = 1; j < 4; j++)
        if (chr_banks[(4*h+j)*CW +: CW] != chr_banks[(4*h)*CW +: CW] + CW'(j))
          chr_groups_ok = 1'b0;
    end
  end

  assert_chr_groups_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chr_groups_ok);

endmodule

bind serial_bank_mapper serial_bank_mapper_chk #(
  .PRG_BANKS(PRG_BANKS),
  .CHR_PAGES(CHR_PAGES)
) chk_i (.*);

// File: tb/serial_bank_mapper_tb_top.sv
module serial_bank_mapper_tb_top;
  localparam int P  = 8;
  localparam int C  = 32;
  localparam int PW = $clog2(P);
  localparam int CW = $clog2(C);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4*PW-1:0] prg_banks;
  logic [8*CW-1:0] chr_banks;
  logic [1:0] mirror_mode;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  serial_bank_mapper #(.PRG_BANKS(P), .CHR_PAGES(C)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prg_banks(prg_banks), .chr_banks(chr_banks), .mirror_mode(mirror_mode));

  int m_prg[4];
  int m_chr[8];
  int m_mir, m_sh, m_cnt;
  bit m_c4, m_p16, m_lo;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_prg[i] = P - 4 + i;
    for (int i = 0; i < 8; i++) m_chr[i] = i;
    m_mir = 2; m_sh = 0; m_cnt = 0; m_c4 = 0; m_p16 = 1; m_lo = 1;
  endtask

  task automatic model_commit(int sel, int v);
    case (sel)
      0: begin m_mir = v & 3; m_lo = v[2]; m_p16 = v[3]; m_c4 = v[4]; end
      1: for (int j = 0; j < (m_c4 ? 4 : 8); j++) m_chr[j] = (4*v + j) % C;
      2: if (m_c4) for (int j = 0; j < 4; j++) m_chr[4+j] = (4*v + j) % C;
      default:
        if (m_p16) begin
          for (int k = 0; k < 2; k++) m_prg[(m_lo ? 0 : 2) + k] = (2*v + k) % P;
        end else begin
          for (int i = 0; i < 4; i++) m_prg[i] = (4*(v >> 1) + i) % P;
        end
    endcase
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    int nsh;
    if (!a[15]) return;
    if (d[7]) begin
      m_sh = 0; m_cnt = 0; m_p16 = 1; m_lo = 1; m_c4 = 0;
    end else begin
      nsh = (int'(d[0]) << 4) | (m_sh >> 1);
      m_sh = nsh;
      if (m_cnt == 4) begin
        m_cnt = 0;
        model_commit(int'(a[14:13]), nsh);
      end else m_cnt++;
    end
  endtask

  task automatic check(string tag);
    logic [4*PW-1:0] ep;
    logic [8*CW-1:0] ec;
    for (int i = 0; i < 4; i++) ep[i*PW +: PW] = PW'(m_prg[i]);
    for (int i = 0; i < 8; i++) ec[i*CW +: CW] = CW'(m_chr[i]);
    checks++;
    if (prg_banks !== ep || chr_banks !== ec || mirror_mode !== 2'(m_mir)) begin
      errors++;
      $display("FAIL %s: prg=%h chr=%h mir=%0d expected prg=%h chr=%h mir=%0d",
               tag, prg_banks, chr_banks, mirror_mode, ep, ec, m_mir);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d, logic en = 1'b1);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en) model_write(a, d);
  endtask

  task automatic load5(int sel, int v, string tag);
    logic [15:0] a;
    a = 16'h8000 | 16'(sel << 13) | 16'(sel * 7);
    for (int k = 0; k < 5; k++) begin
      bus_write(a, {7'd0, v[k]});
      if (k == 3) check("R3 partial load holds outputs");
    end
    check(tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset state");

    load5(3, 5, "R7 16K lower half after reset");
    load5(0, 5'b01011, "R4 mirror horizontal, upper half switchable");
    load5(3, 6, "R7 16K upper half");
    load5(0, 5'b00000, "R4 mirror single low, 32K mode");
    load5(3, 31, "R8 R7 32K mode with wrap");
    load5(0, 5'b00001, "R4 mirror single high");
    load5(1, 3, "R5 lower char 8K mode");
    load5(2, 9, "R6 upper char ignored in 8K mode");
    load5(0, 5'b10010, "R4 mirror vertical, 4K char");
    load5(1, 30, "R8 R5 lower char 4K mode wrap");
    load5(2, 7, "R6 upper char 4K mode");

    bus_write(16'hA000, 8'h01);
    bus_write(16'hA000, 8'h00);
    bus_write(16'hE000, 8'h80);
    check("R1 clear write holds outputs");
    load5(3, 4, "R1 count restarted, 16K lower selected");
    load5(1, 2, "R1 char back in 8K mode");

    bus_write(16'h6000, 8'h01);
    bus_write(16'h7FFF, 8'h01);
    bus_write(16'hE000, 8'h01, 1'b0);
    load5(3, 2, "R2 ignored writes left count intact");

    void'($urandom(32'd4242));
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [7:0] d;
      a = 16'($urandom);
      d = 8'($urandom) & 8'h7F;
      if ($urandom % 10 == 0) d[7] = 1'b1;
      bus_write(a, d, 1'($urandom % 8 != 0));
      check("R10 random traffic");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule